// File: doc/BRIEF.md
# Per-Channel ADC Threshold Comparator

This block sits beside a multi-channel analog-to-digital converter and watches its results. For every channel it keeps three settings: a 10-bit threshold, a two-bit comparison mode and a four-bit resolution code. When the scan sequencer signals the end of a scan, each channel that delivered a fresh result in that scan has its result trimmed to the configured resolution and compared with its threshold. A channel whose selected condition holds sets its own sticky flag. Channels that did not deliver fresh data and cycles without a scan end never set a flag.

Software reaches the settings, the flag vector and an interrupt-enable mask through a simple register port. It writes with a one-cycle strobe and reads with a combinational data path. Flags are cleared by writing ones to the flag register. A single interrupt line is raised while any enabled flag is set. Settings may be rewritten at any time, including in the very cycle a scan ends. The comparison then uses the value held before that write.

Address map: `reg_addr[5:4]` selects the bank (0 = thresholds, 1 = resolution codes, 2 = control) and `reg_addr[3:0]` selects the channel. In the control bank, index 0 is the flag register and index 1 is the enable mask.

Top module: `adc_thresh_cmp`

## Requirements
- R1: After reset every threshold, mode, resolution code, enable bit and flag reads zero, and `irq` is low.
- R2: A threshold register keeps the threshold in bits 9:0 and the mode in bits 17:16. A resolution register keeps its code in bits 3:0. All other bits read zero whatever was written to them.
- R3: Mode 2'b10 sets the channel flag when the trimmed result is strictly below the threshold. Equality does not set it.
- R4: Mode 2'b11 sets the channel flag when the trimmed result is equal to or above the threshold.
- R5: Modes 2'b00 and 2'b01 never set a flag.
- R6: A flag can only be set in a cycle where `scan_done` is high and the channel's `ch_new` bit is high. The flag appears on `irq_flags` after the next rising clock edge.
- R7: With resolution code N (4'd2 to 4'd10), only the top N bits of the 10-bit left-aligned result take part in the comparison, and the lower 10-N bits are treated as zero.
- R8: Resolution code 4'd0, 4'd1 or 4'd11 to 4'd15 stops the channel from ever setting a flag, whatever its mode.
- R9: A threshold written in the same cycle as a scan end does not affect that scan's comparison. It applies from the next scan end.
- R10: A flag stays set until a write to the flag register (bank 2, index 0) carries a 1 in its bit position. Writing 0 leaves a flag untouched.
- R11: If a match and a clear hit the same flag in the same cycle, the flag is set afterwards.
- R12: `irq` is high exactly when some flag is set whose bit in the enable mask (bank 2, index 1) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address: bank in bits 5:4, channel index in bits 3:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| scan_done | input | 1 | One-cycle end-of-scan strobe |
| ch_new | input | 16 | Per-channel fresh-result indication, qualified by `scan_done` |
| ch_result | input | 160 | Channel results, 10 bits each, left-aligned, channel c at bits 10c+9:10c |
| irq_flags | output | 16 | Sticky per-channel match flags |
| irq | output | 1 | Combined interrupt: OR of flags masked by the enable mask |

## Verification
The hardest situations to reach are the ones where two independent sources meet on the same cycle. One is a threshold rewrite colliding with a scan end. The other is a software clear colliding with a match on the same flag. The stimulus task drives the scan strobe and a register write on the same clock edge, so both collisions are reproduced exactly. Resolution trimming is reached by choosing results that differ from the threshold only in bits below the configured resolution, so the flag depends entirely on the masking.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;

  localparam int DATA_W = 10;

  localparam logic [1:0] BANK_THR = 2'd0;
  localparam logic [1:0] BANK_RES = 2'd1;
  localparam logic [1:0] BANK_CTL = 2'd2;

  localparam int CTL_FLAGS = 0;
  localparam int CTL_MASK  = 1;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_SPARE    = 2'b01,
    MODE_BELOW    = 2'b10,
    MODE_AT_ABOVE = 2'b11
  } cmp_mode_e;

  // True for resolution codes 2..10.
  function automatic logic res_is_valid(input logic [3:0] code);
    return (code >= 4'd2) && (code <= 4'd10);
  endfunction

  // Keep the top "code" bits of a left-aligned result.
  function automatic logic [DATA_W-1:0] res_keep_mask(input logic [3:0] code);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      m[i] = (i >= (DATA_W - int'(code)));
    end
    return m;
  endfunction

endpackage

// File: rtl/adc_cmp_cfg.sv
module adc_cmp_cfg
  import adc_cmp_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_bank_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_data_i,
  output logic [DATA_W-1:0] thr_o  [NUM_CH],
  output cmp_mode_e         mode_o [NUM_CH],
  output logic [3:0]        res_o  [NUM_CH],
  output logic [NUM_CH-1:0] en_mask_o
);

  logic [DATA_W-1:0] thr_q  [NUM_CH];
  logic [DATA_W-1:0] thr_d  [NUM_CH];
  cmp_mode_e         mode_q [NUM_CH];
  cmp_mode_e         mode_d [NUM_CH];
  logic [3:0]        res_q  [NUM_CH];
  logic [3:0]        res_d  [NUM_CH];
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] en_d;

  logic thr_wr;
  logic res_wr;
  logic en_wr;

  assign thr_wr = wr_en_i && (wr_bank_i == BANK_THR);
  assign res_wr = wr_en_i && (wr_bank_i == BANK_RES);
  assign en_wr  = wr_en_i && (wr_bank_i == BANK_CTL) && (int'(wr_idx_i) == CTL_MASK);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      thr_d[c]  = thr_q[c];
      mode_d[c] = mode_q[c];
      res_d[c]  = res_q[c];
      if (thr_wr && (int'(wr_idx_i) == c)) begin
        thr_d[c]  = wr_data_i[DATA_W-1:0];
        mode_d[c] = cmp_mode_e'(wr_data_i[17:16]);
      end
      if (res_wr && (int'(wr_idx_i) == c)) begin
        res_d[c] = wr_data_i[3:0];
      end
    end
    en_d = en_wr ? wr_data_i[NUM_CH-1:0] : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        thr_q[c]  <= '0;
        mode_q[c] <= MODE_OFF;
        res_q[c]  <= '0;
      end
      en_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        thr_q[c]  <= thr_d[c];
        mode_q[c] <= mode_d[c];
        res_q[c]  <= res_d[c];
      end
      en_q <= en_d;
    end
  end

  assign thr_o     = thr_q;
  assign mode_o    = mode_q;
  assign res_o     = res_q;
  assign en_mask_o = en_q;

  // R12 support: the enable mask only moves on a write strobe
  a_r12_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(en_q));

endmodule

// File: rtl/adc_cmp_lane.sv
module adc_cmp_lane
  import adc_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_done_i,
  input  logic              new_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] thr_i,
  input  cmp_mode_e         mode_i,
  input  logic [3:0]        res_i,
  output logic              hit_o
);

  logic [DATA_W-1:0] trimmed;
  logic              below;
  logic              cond;
  logic              armed;

  assign trimmed = result_i & res_keep_mask(res_i);
  assign below   = trimmed < thr_i;
  assign armed   = scan_done_i && new_i && res_is_valid(res_i);

  always_comb begin
    unique case (mode_i)
      MODE_BELOW:    cond = below;
      MODE_AT_ABOVE: cond = !below;
      default:       cond = 1'b0;
    endcase
  end

  assign hit_o = armed && cond;

  a_r5_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_OFF || mode_i == MODE_SPARE) |-> !hit_o);

  a_r6_scan_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_done_i || !new_i) |-> !hit_o);

  a_r8_res_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (res_i < 4'd2 || res_i > 4'd10) |-> !hit_o);

endmodule

// File: rtl/adc_cmp_flags.sv
module adc_cmp_flags #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_done_i,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic [NUM_CH-1:0] en_mask_i,
  output logic [NUM_CH-1:0] flags_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] flags_q;
  logic [NUM_CH-1:0] flags_d;

  always_comb begin
    flags_d = (flags_q & ~clr_i) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_mask_i);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i)));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(hit_i)) == $past(hit_i)));

  a_r6_no_scan_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done_i |=> ((flags_q & ~$past(flags_q)) == '0));

  a_r12_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_q != '0));

endmodule

// File: rtl/adc_thresh_cmp.sv
module adc_thresh_cmp
  import adc_cmp_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int IDX_W  = $clog2(NUM_CH),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic                     scan_done,
  input  logic [NUM_CH-1:0]        ch_new,
  input  logic [NUM_CH*DATA_W-1:0] ch_result,
  output logic [NUM_CH-1:0]        irq_flags,
  output logic                     irq
);

  // Reset: asserts at once, releases after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  logic [1:0]       bank;
  logic [IDX_W-1:0] idx;
  assign bank = reg_addr[ADDR_W-1 -: 2];
  assign idx  = reg_addr[IDX_W-1:0];

  logic [DATA_W-1:0] thr  [NUM_CH];
  cmp_mode_e         mode [NUM_CH];
  logic [3:0]        res  [NUM_CH];
  logic [NUM_CH-1:0] en_mask;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] clr;

  adc_cmp_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (reg_we),
    .wr_bank_i (bank),
    .wr_idx_i  (idx),
    .wr_data_i (reg_wdata),
    .thr_o     (thr),
    .mode_o    (mode),
    .res_o     (res),
    .en_mask_o (en_mask)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    adc_cmp_lane u_lane (
      .clk         (clk),
      .rst_n       (rst_n_int),
      .scan_done_i (scan_done),
      .new_i       (ch_new[c]),
      .result_i    (ch_result[c*DATA_W +: DATA_W]),
      .thr_i       (thr[c]),
      .mode_i      (mode[c]),
      .res_i       (res[c]),
      .hit_o       (hit[c])
    );
  end

  assign clr = (reg_we && (bank == BANK_CTL) && (int'(idx) == CTL_FLAGS))
             ? reg_wdata[NUM_CH-1:0] : '0;

  adc_cmp_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .scan_done_i (scan_done),
    .hit_i       (hit),
    .clr_i       (clr),
    .en_mask_i   (en_mask),
    .flags_o     (irq_flags),
    .irq_o       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (bank)
      BANK_THR: begin
        reg_rdata[DATA_W-1:0] = thr[idx];
        reg_rdata[17:16]      = mode[idx];
      end
      BANK_RES: reg_rdata[3:0] = res[idx];
      BANK_CTL: begin
        if (int'(idx) == CTL_FLAGS) reg_rdata[NUM_CH-1:0] = irq_flags;
        else if (int'(idx) == CTL_MASK) reg_rdata[NUM_CH-1:0] = en_mask;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R2: reserved bits of a threshold register read zero
  a_r2_thr_reserved: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bank == BANK_THR) |-> (reg_rdata[31:18] == '0 && reg_rdata[15:DATA_W] == '0));

endmodule

// File: tb/adc_thresh_cmp_tb.sv
module adc_thresh_cmp_tb;

  localparam int NCH = 16;
  localparam int DW  = 10;

  logic          clk;
  logic          rst_n;
  logic          reg_we;
  logic [5:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          scan_done;
  logic [NCH-1:0] ch_new;
  logic [NCH*DW-1:0] ch_result;
  logic [NCH-1:0] irq_flags;
  logic          irq;

  logic [DW-1:0] res_in [NCH];

  adc_thresh_cmp u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .scan_done (scan_done),
    .ch_new    (ch_new),
    .ch_result (ch_result),
    .irq_flags (irq_flags),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) ch_result[c*DW +: DW] = res_in[c];
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench-side model built from the requirements
  logic [DW-1:0] thr_m  [NCH];
  logic [1:0]    mode_m [NCH];
  logic [3:0]    res_m  [NCH];
  logic [NCH-1:0] flags_m;
  logic [NCH-1:0] en_m;

  typedef struct {
    logic [NCH-1:0] flags;
    logic           irq;
    string          tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic logic model_hit(int c);
    logic [DW-1:0] a;
    if (res_m[c] < 4'd2 || res_m[c] > 4'd10) return 1'b0;
    a = res_in[c] & (10'h3FF << (10 - int'(res_m[c])));
    case (mode_m[c])
      2'b10:   return a < thr_m[c];
      2'b11:   return a >= thr_m[c];
      default: return 1'b0;
    endcase
  endfunction

  // Driver: one cycle of stimulus, expected flags pushed to the scoreboard
  task automatic step(input logic sd, input logic [NCH-1:0] nv, input logic we,
                      input logic [5:0] addr, input logic [31:0] wd, input string tag);
    logic [NCH-1:0] hits;
    logic [NCH-1:0] clrv;
    exp_t e;
    @(negedge clk);
    scan_done = sd; ch_new = nv; reg_we = we; reg_addr = addr; reg_wdata = wd;
    hits = '0;
    for (int c = 0; c < NCH; c++) if (sd && nv[c]) hits[c] = model_hit(c);
    clrv = (we && addr == 6'h20) ? wd[NCH-1:0] : '0;
    flags_m = (flags_m & ~clrv) | hits;
    if (we) begin
      case (addr[5:4])
        2'd0: begin thr_m[addr[3:0]] = wd[9:0]; mode_m[addr[3:0]] = wd[17:16]; end
        2'd1: res_m[addr[3:0]] = wd[3:0];
        2'd2: if (addr[3:0] == 4'd1) en_m = wd[NCH-1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    scan_done = 1'b0; ch_new = '0; reg_we = 1'b0;
    e.flags = flags_m; e.irq = |(flags_m & en_m); e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic set_thr(input int c, input logic [1:0] m, input logic [9:0] v, input string tag);
    step(0, '0, 1, {2'd0, 4'(c)}, 32'hFFFC_FC00 | ({30'b0, m} << 16) | {22'b0, v}, tag);
  endtask

  task automatic set_res(input int c, input logic [3:0] r, input string tag);
    step(0, '0, 1, {2'd1, 4'(c)}, 32'hFFFF_FFF0 | {28'b0, r}, tag);
  endtask

  task automatic rd(input logic [5:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = addr;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read addr %h got %h expected %h", tag, addr, reg_rdata, exp);
    end
  endtask

  // Monitor: compare outputs against scoreboard items
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (irq_flags !== e.flags || irq !== e.irq) begin
          errors++;
          $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b",
                   e.tag, irq_flags, irq, e.flags, e.irq);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    scan_done = 0; ch_new = '0;
    for (int c = 0; c < NCH; c++) begin
      res_in[c] = '0; thr_m[c] = '0; mode_m[c] = '0; res_m[c] = '0;
    end
    flags_m = '0; en_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    step(0, '0, 0, 6'h00, 0, "R1 reset flags");
    rd(6'h00, 32'h0, "R1 threshold reset");
    rd(6'h1F, 32'h0, "R1 resolution reset");
    rd(6'h21, 32'h0, "R1 mask reset");

    // configuration
    step(0, '0, 1, 6'h21, 32'h0000_FFFF, "R12 mask all");
    for (int c = 3; c <= 10; c++) set_res(c, (c == 9) ? 4'd8 : (c == 10) ? 4'd2 : 4'd10, "R2 res cfg");
    set_res(11, 4'd0, "R8 cfg"); set_res(12, 4'd1, "R8 cfg"); set_res(13, 4'd12, "R8 cfg");
    set_thr(3, 2'b10, 10'h155, "R3 cfg"); set_thr(4, 2'b10, 10'h155, "R3 cfg");
    set_thr(5, 2'b11, 10'h100, "R4 cfg"); set_thr(6, 2'b11, 10'h100, "R4 cfg");
    set_thr(7, 2'b00, 10'h200, "R5 cfg"); set_thr(8, 2'b01, 10'h200, "R5 cfg");
    set_thr(9, 2'b10, 10'h201, "R7 cfg"); set_thr(10, 2'b11, 10'h300, "R7 cfg");
    for (int c = 11; c <= 13; c++) set_thr(c, 2'b11, 10'h000, "R8 cfg");

    // R2 readback with reserved bits masked
    rd(6'h03, 32'h0002_0155, "R2 threshold readback");
    rd(6'h05, 32'h0003_0100, "R2 mode readback");
    rd(6'h19, 32'h0000_0008, "R2 resolution readback");

    // R3 R4 R5 R7 R8 in one scan
    res_in[3] = 10'h154; res_in[4] = 10'h155; res_in[5] = 10'h100; res_in[6] = 10'h0FF;
    res_in[7] = 10'h000; res_in[8] = 10'h000; res_in[9] = 10'h203; res_in[10] = 10'h2FF;
    res_in[11] = 10'h3FF; res_in[12] = 10'h3FF; res_in[13] = 10'h3FF;
    step(1, 16'h3FF8, 0, 6'h00, 0, "R3 R4 R5 R7 R8 scan");
    rd(6'h20, 32'h0000_0228, "R3 R4 R5 R7 R8 flag register");

    // R10 partial clear: only bit 5 cleared
    step(0, '0, 1, 6'h20, 32'h0000_0020, "R10 clear one");
    rd(6'h20, 32'h0000_0208, "R10 others kept");
    step(0, '0, 1, 6'h20, 32'h0000_0000, "R10 zero write no effect");
    step(0, '0, 1, 6'h20, 32'h0000_FFFF, "R10 clear all");

    // R6 gating
    step(0, 16'hFFFF, 0, 6'h00, 0, "R6 new without scan end");
    step(1, 16'h0000, 0, 6'h00, 0, "R6 scan end without new");

    // R7 coarse resolution: 0x3FF trims to 0x300 at 2 bits
    res_in[10] = 10'h3FF;
    step(1, 16'h0400, 0, 6'h00, 0, "R7 trimmed equal");
    step(0, '0, 1, 6'h20, 32'h0000_FFFF, "R10 clear");

    // R9 threshold rewrite during scan end
    step(1, 16'h0008, 1, 6'h03, 32'h0002_0100, "R9 old threshold used");
    step(0, '0, 1, 6'h20, 32'h0000_FFFF, "R9 clear");
    step(1, 16'h0008, 0, 6'h00, 0, "R9 new threshold used");
    rd(6'h03, 32'h0002_0100, "R9 new threshold readback");

    // R11 set beats clear
    step(1, 16'h0020, 1, 6'h20, 32'h0000_0020, "R11 set wins");

    // R12 mask
    step(0, '0, 1, 6'h21, 32'h0000_0008, "R12 masked off");
    step(0, '0, 1, 6'h21, 32'h0000_0020, "R12 masked on");
    step(0, '0, 0, 6'h00, 0, "R12 hold");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule